// File: doc/BRIEF.md
# Universal Shift and Storage Register with Shared Data Pins

This block is a storage register of parameterised width, eight bits by default. On each rising clock edge it holds its contents, shifts them one place in either direction, or loads a new word in parallel. Two select inputs choose the operation. The parallel load data and the register contents share one set of bidirectional pins. Each pin is modelled as a value output, a common drive-enable output and a sampled input, so a pad wrapper can build the tri-state buffer from them.

The drivers are on only when both active-low output enables are low and the selects are not asking for a load. The drivers turn off by themselves during a load, which lets an external source put the load word on the shared pins. The end bits of the register also appear on two outputs that are always driven. Several blocks can be chained through these outputs to form a longer shift chain. An active-low master reset clears the register at once, without waiting for a clock edge.

Top module: `usr_shift_store`

## Requirements
- R1: While `rst_n` is low the register is zero. This holds at once, without a clock edge, and whatever the selects are.
- R2: With {sel1,sel0}=00 the register keeps its value, and `pin_in` and both serial inputs have no effect.
- R3: With {sel1,sel0}=01 each bit n moves to bit n+1 on the rising edge, and bit 0 takes `ser_lo_in`.
- R4: With {sel1,sel0}=10 each bit n moves to bit n-1 on the rising edge, and the top bit takes `ser_hi_in`.
- R5: With {sel1,sel0}=11 the register takes the value on `pin_in` at the rising edge.
- R6: `pin_drive` is high exactly when `oe_a_n` and `oe_b_n` are both low and {sel1,sel0} is not 11. `pin_out` equals the register while `pin_drive` is high and is all zeros while it is low.
- R7: With {sel1,sel0}=11, `pin_drive` is low whatever the output enables are.
- R8: Hold, shift, load and reset work the same while the drivers are off. The value built up in that time shows on `pin_out` once the drivers turn back on.
- R9: `tap_lo` always equals register bit 0 and `tap_hi` always equals the top bit, whatever the output enables and selects are.
- R10: During a right shift `ser_hi_in` has no effect, and during a left shift `ser_lo_in` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| sel0 | input | 1 | Operation select, low bit |
| sel1 | input | 1 | Operation select, high bit |
| ser_lo_in | input | 1 | Serial fill for bit 0 on a right shift |
| ser_hi_in | input | 1 | Serial fill for the top bit on a left shift |
| oe_a_n | input | 1 | Output enable A, active low |
| oe_b_n | input | 1 | Output enable B, active low |
| pin_in | input | WIDTH | Sampled value of the shared pins |
| pin_out | output | WIDTH | Value driven onto the shared pins |
| pin_drive | output | 1 | Drive enable for the shared pins |
| tap_lo | output | 1 | Register bit 0, always driven |
| tap_hi | output | 1 | Register top bit, always driven |

## Verification
The assertions assume that the selects, serial inputs, enables and `pin_in` are steady around each rising clock edge, because they compare the register with the values sampled at the previous edge. They also assume that `rst_n` is low from time zero. The bench meets this by changing every input only on the falling clock edge. The one exception is a reset pulse applied mid-cycle to show the asynchronous clear, and the bench releases that pulse on a falling edge as well.

// File: rtl/usr_pkg.sv
package usr_pkg;

  typedef enum logic [1:0] {
    OP_KEEP  = 2'b00,
    OP_UP    = 2'b01,
    OP_DOWN  = 2'b10,
    OP_LOAD  = 2'b11
  } usr_op_e;

  // Map the two select pins to an operation.
  function automatic usr_op_e sel_to_op(input logic s1, input logic s0);
    return usr_op_e'({s1, s0});
  endfunction

  // Next value of one bit slice.
  function automatic logic slice_next(input usr_op_e op, input logic self_q,
                                      input logic from_lower, input logic from_upper,
                                      input logic par_bit);
    logic r;
    unique case (op)
      OP_KEEP: r = self_q;
      OP_UP:   r = from_lower;
      OP_DOWN: r = from_upper;
      default: r = par_bit;
    endcase
    return r;
  endfunction

  // Drivers allowed only when both enables are asserted and no load is pending.
  function automatic logic drive_allowed(input logic en_a_n, input logic en_b_n,
                                         input logic load_req);
    return !en_a_n && !en_b_n && !load_req;
  endfunction

endpackage

// File: rtl/usr_mode_dec.sv
module usr_mode_dec
  import usr_pkg::*;
(
  input  logic    sel0,
  input  logic    sel1,
  output usr_op_e op,
  output logic    load_win
);

  assign op       = sel_to_op(sel1, sel0);
  assign load_win = (op == OP_LOAD);

endmodule

// File: rtl/usr_datapath.sv
module usr_datapath
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  usr_op_e          op,
  input  logic             ser_lo,
  input  logic             ser_hi,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] q
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] d;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    logic lower_src;
    logic upper_src;
    if (i == 0) begin : g_first
      assign lower_src = ser_lo;
    end else begin : g_mid_lo
      assign lower_src = q[i-1];
    end
    if (i == TOP) begin : g_last
      assign upper_src = ser_hi;
    end else begin : g_mid_hi
      assign upper_src = q[i+1];
    end
    assign d[i] = slice_next(op, q[i], lower_src, upper_src, par_in[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk) !rst_n |=> q == '0);

  // R2
  keep_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_KEEP |=> $stable(q));

  // R3
  up_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_UP |=> q == {$past(q[TOP-1:0]), $past(ser_lo)});

  // R4
  down_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_DOWN |=> q == {$past(ser_hi), $past(q[TOP:1])});

  // R5
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_LOAD |=> q == $past(par_in));

endmodule

// File: rtl/usr_pin_drv.sv
module usr_pin_drv
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             en_a_n,
  input  logic             en_b_n,
  input  logic             load_win,
  input  logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] pin_out,
  output logic             pin_drive
);

  assign pin_drive = drive_allowed(en_a_n, en_b_n, load_win);
  assign pin_out   = pin_drive ? q : '0;

endmodule

// File: rtl/usr_shift_store.sv
module usr_shift_store
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel0,
  input  logic             sel1,
  input  logic             ser_lo_in,
  input  logic             ser_hi_in,
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic             pin_drive,
  output logic             tap_lo,
  output logic             tap_hi
);

  localparam int TOP = WIDTH - 1;

  usr_op_e          op;
  logic             load_win;
  logic [WIDTH-1:0] store_q;

  usr_mode_dec u_dec (
    .sel0     (sel0),
    .sel1     (sel1),
    .op       (op),
    .load_win (load_win)
  );

  usr_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (op),
    .ser_lo (ser_lo_in),
    .ser_hi (ser_hi_in),
    .par_in (pin_in),
    .q      (store_q)
  );

  usr_pin_drv #(.WIDTH(WIDTH)) u_drv (
    .en_a_n    (oe_a_n),
    .en_b_n    (oe_b_n),
    .load_win  (load_win),
    .q         (store_q),
    .pin_out   (pin_out),
    .pin_drive (pin_drive)
  );

  assign tap_lo = store_q[0];
  assign tap_hi = store_q[TOP];

  // R7
  load_drv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel0 && sel1) |-> !pin_drive);

  // R6
  oe_high_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_a_n || oe_b_n) |-> !pin_drive);

  // R6
  quiet_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_drive |-> pin_out == '0);

  // R9
  taps_match_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_drive |-> (pin_out[0] == tap_lo) && (pin_out[TOP] == tap_hi));

endmodule

// File: tb/usr_shift_store_bench.sv
module usr_shift_store_bench;

  localparam int W = 8;
  localparam int NV = 14;

  // {sel[1:0], ser_lo, ser_hi, oe_a_n, oe_b_n, pin_in[7:0], expected[7:0]}
  localparam logic [21:0] VEC [NV] = '{
    {2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5},  // R5 load
    {2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hA5},  // R2 hold ignores inputs
    {2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h4B},  // R3 right, fill 1
    {2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h96},  // R3 R10 ser_hi ignored
    {2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'hCB},  // R4 left, fill 1
    {2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h65},  // R4 R10 ser_lo ignored
    {2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h65},  // R6 enable A off
    {2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'hCB},  // R8 shift while off
    {2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C, 8'h3C},  // R7 load turns drivers off
    {2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h1E},  // R8 left while off
    {2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h1E},  // R8 value shows again
    {2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h3C},  // R3 fill 0
    {2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h9E},  // R4
    {2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00}   // R5 R7 load zero
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sel0 = 1'b0, sel1 = 1'b0;
  logic         ser_lo_in = 1'b0, ser_hi_in = 1'b0;
  logic         oe_a_n = 1'b0, oe_b_n = 1'b0;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] pin_out;
  logic         pin_drive;
  logic         tap_lo, tap_hi;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  usr_shift_store #(.WIDTH(W)) u_usr_shift_store (
    .clk(clk), .rst_n(rst_n), .sel0(sel0), .sel1(sel1),
    .ser_lo_in(ser_lo_in), .ser_hi_in(ser_hi_in),
    .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .pin_in(pin_in),
    .pin_out(pin_out), .pin_drive(pin_drive), .tap_lo(tap_lo), .tap_hi(tap_hi)
  );

  task automatic check_outputs(input string req, input logic [W-1:0] exp_reg);
    logic         exp_drv;
    logic [W-1:0] exp_pins;
    exp_drv  = !oe_a_n && !oe_b_n && !(sel0 && sel1);
    exp_pins = exp_drv ? exp_reg : '0;
    checks++;
    if (pin_drive !== exp_drv || pin_out !== exp_pins ||
        tap_lo !== exp_reg[0] || tap_hi !== exp_reg[W-1]) begin
      fails++;
      $display("FAIL %s: drive=%b pins=%h taps=%b%b expected drive=%b pins=%h taps=%b%b",
               req, pin_drive, pin_out, tap_hi, tap_lo,
               exp_drv, exp_pins, exp_reg[W-1], exp_reg[0]);
    end
  endtask

  task automatic drive_inputs(input logic [21:0] v);
    {sel1, sel0, ser_lo_in, ser_hi_in, oe_a_n, oe_b_n, pin_in} = v[21:8];
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_outputs("R1 reset state", 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs("R1 after release", 8'h00);

    foreach (VEC[k]) begin
      drive_inputs(VEC[k]);
      @(negedge clk);
      check_outputs($sformatf("R2-5 vector %0d", k), VEC[k][7:0]);
    end

    // R9: taps follow the register while drivers are off
    drive_inputs({2'b11, 4'b0011, 8'hFF, 8'h00});
    @(negedge clk);
    check_outputs("R9 taps with enables high", 8'hFF);

    // R1: asynchronous clear mid-cycle, load select held
    drive_inputs({2'b11, 4'b0000, 8'hFF, 8'h00});
    #2 rst_n = 1'b0;
    #1 checks++;
    if (tap_lo !== 1'b0 || tap_hi !== 1'b0) begin
      fails++;
      $display("FAIL R1 async clear: taps=%b%b expected 00", tap_hi, tap_lo);
    end
    @(negedge clk);
    check_outputs("R1 clear overrides load", 8'h00);
    rst_n = 1'b1;

    // R3 R9: walk a single one up to the top tap
    drive_inputs({2'b11, 4'b0000, 8'h01, 8'h00});
    @(negedge clk);
    check_outputs("R5 seed", 8'h01);
    for (int s = 1; s <= W; s++) begin
      drive_inputs({2'b01, 4'b0000, 8'h00, 8'h00});
      @(negedge clk);
      check_outputs("R3 R9 walk", (s < W) ? W'(1 << s) : '0);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule